// File: doc/BRIEF.md
# Bounded-Range Up/Down Position Counter

This block keeps a 16-bit position count that an encoder front end steps with separate count-up and count-down pulses. The count stays between zero and a programmable upper limit N. Counting up from the limit returns the count to zero. Counting down from zero reloads the limit. The result is a counter that wraps in both directions, for example over one mechanical revolution.

The limit is written through a small register port. Match detection does not compare against that register directly. It compares against a shadow copy. The shadow takes the register value while the counter is stopped, and again each time a match clears the count. A new limit written while the counter runs therefore takes effect only at the next wrap point.

The clear and reload features each have an enable. Reload acts only in encoder compare mode. With a feature disabled, the counter behaves as a plain 16-bit up/down counter.

Top module: `range_enc_counter`

## Requirements
- R1: While reset is asserted and after it is released, the count is 0 and both flag outputs are 0.
- R2: While `run` is 1 and only one of `cnt_up`/`cnt_dn` is 1, the count rises or falls by exactly one on that clock edge.
- R3: The count holds when `run` is 0, or when `cnt_up` and `cnt_dn` are both 1 in the same cycle.
- R4: An up step taken while the count equals the shadow limit sets the count to 0 if `match_clr_en` is 1. If `match_clr_en` is 0, the same step increments the count instead.
- R5: A down step taken while the count equals the shadow limit simply decrements the count.
- R6: A down step at count 0, with `reload_en` and `enc_mode` both 1, loads the value of the limit register into the count.
- R7: A down step at count 0 gives FFFFh when `reload_en` is 0 or `enc_mode` is 0.
- R8: The shadow limit copies the limit register on every edge while `run` is 0, and on the edge of each match clear. A limit written while running does not move the wrap point until the next match clear.
- R9: `match_pulse` is 1 for the one cycle after an up or down step (not a write) leaves the count equal to the shadow limit.
- R10: `under_pulse` is 1 for the one cycle after a down step taken at count 0.
- R11: A write with `wr_en`=1 and `wr_sel`=1 loads `wr_data` into the count on that edge, ahead of any step. A write with `wr_sel`=0 loads the limit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter running; 0 freezes the count and tracks the limit into the shadow |
| cnt_up | input | 1 | Count-up enable for this cycle |
| cnt_dn | input | 1 | Count-down enable for this cycle |
| match_clr_en | input | 1 | Enables clear-to-zero on an up step at the limit |
| enc_mode | input | 1 | Encoder compare mode select |
| reload_en | input | 1 | Enables loading the limit on underflow (only in encoder compare mode) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 limit register, 1 count |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current count |
| match_pulse | output | 1 | One-cycle match flag |
| under_pulse | output | 1 | One-cycle underflow flag |

## Verification
The bench walks full wraps in both directions. It checks that the step at the limit clears to zero, which an off-by-one compare would turn into a step to N+1. It checks that a down step at zero lands on N rather than FFFFh. It also checks that a down step taken at N only decrements, which catches a design that clears on any step at the limit.

Further checks cover underflow with reload disabled and with encoder mode off, each of which must still give FFFFh. Simultaneous up and down pulses must hold the count. A limit is rewritten in the middle of a count. A design that compared against the live register would wrap at the new value at once, instead of completing the current range first.

// File: rtl/rec_pkg.sv
package rec_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;

  typedef enum logic {
    SEL_LIMIT = 1'b0,
    SEL_COUNT = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/rec_rst_sync.sv
module rec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/rec_step_decode.sv
module rec_step_decode
  import rec_pkg::*;
(
  input  logic  run,
  input  logic  cnt_up,
  input  logic  cnt_dn,
  output step_e step
);
  always_comb begin
    step = STEP_HOLD;
    if (run && cnt_up && !cnt_dn)      step = STEP_UP;
    else if (run && cnt_dn && !cnt_up) step = STEP_DOWN;
  end
endmodule

// File: rtl/rec_limit_regs.sv
module rec_limit_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         run,
  input  logic         wr_limit,
  input  logic [W-1:0] wr_data,
  input  logic         clr_evt,
  output logic [W-1:0] limit_q,
  output logic [W-1:0] shadow_q
);
  logic [W-1:0] limit_d, shadow_d;
  logic         shadow_en;

  always_comb begin
    limit_d   = wr_limit ? wr_data : limit_q;
    shadow_en = !run || clr_evt;
    shadow_d  = limit_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      limit_q  <= '1;
      shadow_q <= '1;
    end else begin
      if (wr_limit)  limit_q  <= limit_d;
      if (shadow_en) shadow_q <= shadow_d;
    end
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (run && !clr_evt) |=> (shadow_q == $past(shadow_q)));

  // R8
  shadow_take_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_evt |=> (shadow_q == $past(limit_q)));
endmodule

// File: rtl/rec_count_core.sv
module rec_count_core
  import rec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  step_e        step,
  input  logic         cnt_wr,
  input  logic [W-1:0] wr_data,
  input  logic         match_clr_en,
  input  logic         reload_act,
  input  logic [W-1:0] limit_q,
  input  logic [W-1:0] shadow_q,
  output logic [W-1:0] count_q,
  output logic         match_q,
  output logic         under_q,
  output logic         clr_evt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_d;
  logic         cnt_en, at_lim, at_zero, under_d, match_d;

  always_comb begin
    cnt_d   = count_q;
    clr_evt = 1'b0;
    under_d = 1'b0;
    at_lim  = (count_q == shadow_q);
    at_zero = (count_q == '0);
    cnt_en  = cnt_wr || (step != STEP_HOLD);
    if (cnt_wr) begin
      cnt_d = wr_data;
    end else begin
      case (step)
        STEP_UP: begin
          if (at_lim && match_clr_en) begin
            cnt_d   = '0;
            clr_evt = 1'b1;
          end else begin
            cnt_d = count_q + ONE;
          end
        end
        STEP_DOWN: begin
          if (at_zero) begin
            under_d = 1'b1;
            cnt_d   = reload_act ? limit_q : '1;
          end else begin
            cnt_d = count_q - ONE;
          end
        end
        default: cnt_d = count_q;
      endcase
    end
    match_d = !cnt_wr && (step != STEP_HOLD) && (cnt_d == shadow_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      count_q <= '0;
      match_q <= 1'b0;
      under_q <= 1'b0;
    end else begin
      if (cnt_en) count_q <= cnt_d;
      match_q <= match_d;
      under_q <= under_d;
    end
  end

  // R4
  clear_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cnt_wr && step == STEP_UP && count_q == shadow_q && match_clr_en) |=> (count_q == '0));

  // R6
  reload_on_under_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cnt_wr && step == STEP_DOWN && count_q == '0 && reload_act) |=> (count_q == $past(limit_q)));

  // R7
  wrap_on_under_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cnt_wr && step == STEP_DOWN && count_q == '0 && !reload_act) |=> (count_q == '1));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cnt_wr && step == STEP_HOLD) |=> $stable(count_q));

  // R10
  under_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    under_q |-> ($past(count_q) == '0));

  // R11
  count_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_wr |=> (count_q == $past(wr_data)) && !match_q && !under_q);
endmodule

// File: rtl/range_enc_counter.sv
module range_enc_counter
  import rec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cnt_up,
  input  logic         cnt_dn,
  input  logic         match_clr_en,
  input  logic         enc_mode,
  input  logic         reload_en,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         match_pulse,
  output logic         under_pulse
);
  logic         rst_sn, clr_evt, wr_limit, cnt_wr, reload_act;
  logic [W-1:0] limit_q, shadow_q;
  step_e        step;

  assign wr_limit   = wr_en && (wr_sel_e'(wr_sel) == SEL_LIMIT);
  assign cnt_wr     = wr_en && (wr_sel_e'(wr_sel) == SEL_COUNT);
  assign reload_act = reload_en && enc_mode;

  rec_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  rec_step_decode step_i (
    .run(run), .cnt_up(cnt_up), .cnt_dn(cnt_dn), .step(step)
  );

  rec_limit_regs #(.W(W)) lim_i (
    .clk(clk), .rst_sn(rst_sn), .run(run), .wr_limit(wr_limit),
    .wr_data(wr_data), .clr_evt(clr_evt), .limit_q(limit_q), .shadow_q(shadow_q)
  );

  rec_count_core #(.W(W)) core_i (
    .clk(clk), .rst_sn(rst_sn), .step(step), .cnt_wr(cnt_wr), .wr_data(wr_data),
    .match_clr_en(match_clr_en), .reload_act(reload_act), .limit_q(limit_q),
    .shadow_q(shadow_q), .count_q(count), .match_q(match_pulse),
    .under_q(under_pulse), .clr_evt(clr_evt)
  );

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (run && cnt_up && !cnt_dn && !wr_en && !(match_clr_en && count == shadow_q))
      |=> (count == $past(count) + W'(1)));
endmodule

// File: tb/range_enc_counter_tb_top.sv
module range_enc_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  // {up, dn, expected count, expected match, expected underflow}
  // R2 steps, R3 hold, R4 clear, R5 down at limit, R6 reload, R9 match, R10 underflow
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'd1, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'd2, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'd3, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'd4, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'd5, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'd5, 1'b1, 1'b1},
    {1'b0, 1'b1, 16'd4, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'd4, 1'b0, 1'b0},
    {1'b0, 1'b0, 16'd4, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'd5, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'd4, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'd3, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'd2, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'd1, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'd5, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n, run, cnt_up, cnt_dn, match_clr_en, enc_mode, reload_en;
  logic        wr_en, wr_sel;
  logic [15:0] wr_data, count;
  logic        match_pulse, under_pulse;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  range_enc_counter dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .match_clr_en(match_clr_en), .enc_mode(enc_mode), .reload_en(reload_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .count(count),
    .match_pulse(match_pulse), .under_pulse(under_pulse)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic up, input logic dn);
    cnt_up = up; cnt_dn = dn;
    @(negedge clk);
    cnt_up = 1'b0; cnt_dn = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; cnt_up = 1'b0; cnt_dn = 1'b0;
    match_clr_en = 1'b1; enc_mode = 1'b1; reload_en = 1'b1;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", count, 16'h0);
    check("R1 flags in reset", {14'b0, match_pulse, under_pulse}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 count after reset", count, 16'h0);

    // limit 5 while stopped, let the shadow copy it
    wr(1'b0, 16'd5);
    @(negedge clk);
    cyc(1'b1, 1'b0);
    check("R3 stopped hold", count, 16'h0);
    run = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][19], VEC[i][18]);
      check($sformatf("R2-table count v%0d", i), count, VEC[i][17:2]);
      check($sformatf("R9 table match v%0d", i), {15'b0, match_pulse}, {15'b0, VEC[i][1]});
      check($sformatf("R10 table under v%0d", i), {15'b0, under_pulse}, {15'b0, VEC[i][0]});
    end

    // R7: reload disabled
    reload_en = 1'b0;
    wr(1'b1, 16'h0);
    cyc(1'b0, 1'b1);
    check("R7 no reload wrap", count, 16'hFFFF);
    check("R10 under flag", {15'b0, under_pulse}, 16'h1);
    // R7: encoder mode off
    reload_en = 1'b1; enc_mode = 1'b0;
    wr(1'b1, 16'h0);
    cyc(1'b0, 1'b1);
    check("R7 non-encoder wrap", count, 16'hFFFF);
    enc_mode = 1'b1;

    // R4: clear disabled
    match_clr_en = 1'b0;
    wr(1'b1, 16'd5);
    cyc(1'b1, 1'b0);
    check("R4 no clear increments", count, 16'd6);
    match_clr_en = 1'b1;

    // R11: count write beats a step
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'd3; cnt_up = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_up = 1'b0;
    check("R11 write priority", count, 16'd3);
    check("R11 write no match flag", {15'b0, match_pulse}, 16'h0);

    // R8: limit written while running
    wr(1'b0, 16'd2);
    cyc(1'b1, 1'b0);
    check("R8 old range continues", count, 16'd4);
    cyc(1'b1, 1'b0);
    check("R8 reaches old limit", count, 16'd5);
    cyc(1'b1, 1'b0);
    check("R8 clears at old limit", count, 16'd0);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    check("R8 new limit reached", count, 16'd2);
    check("R9 match at new limit", {15'b0, match_pulse}, 16'h1);
    cyc(1'b1, 1'b0);
    check("R8 clears at new limit", count, 16'd0);

    // R3: stop while pulses arrive
    run = 1'b0;
    cyc(1'b0, 1'b1);
    check("R3 stopped ignores down", count, 16'd0);
    check("R10 no underflow when stopped", {15'b0, under_pulse}, 16'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule